// File: doc/BRIEF.md
# Four-State Snooping Line-State Controller

This block sits beside one processor's cache and tracks the coherence state of every line in a small direct-mapped array. Each line is Modified, Exclusive, Shared or Invalid. The processor presents a line address with a read or write flag. Reads that hit in any valid state complete in the same cycle. A write also completes in that cycle when the line is Modified. When the line is Exclusive, the write completes in that cycle and the line silently becomes Modified. Every other access raises a bus request, either a plain read or a read-for-ownership. In the response cycle that follows the grant, the request completes and the line is installed.

For a read miss, the controller chooses between the Exclusive and Shared fill states. It does this by sampling the wired-OR holder vector from the other agents in the response cycle. Transactions of other agents arrive on the snoop port. One cycle after a snooped address matches a valid line, the controller raises its holder bit. It also raises a data-supply flag if it is the agent that must answer, and then it demotes or invalidates the line. A Modified or Exclusive owner always answers. Among Shared holders, only the holder with the lowest agent index answers.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any line raises a bus request, and proc_done_o, bus_req_o, shared_o and supply_o are low while idle.
- R2: A read miss raises bus_req_o with bus_cmd_o = 0 (plain read) and bus_line_o equal to the requested line. proc_done_o is high in the cycle after the grant. If no other agent's bit is set in shared_vec_i in that cycle, the line fills Exclusive.
- R3: A read miss that sees any other agent's bit in shared_vec_i during its response cycle fills Shared, so a later write to it needs a bus request.
- R4: A write to an Exclusive line completes in the same cycle with no bus request and leaves the line Modified.
- R5: A write to a Shared line, or a write miss, raises bus_cmd_o = 1 (read-for-ownership) and installs the line Modified.
- R6: A read that hits a Modified, Exclusive or Shared line completes in the same cycle with bus_req_o low.
- R7: A snooped read (snoop_cmd_i = 0) that matches a Modified or Exclusive line drives shared_o and supply_o high one cycle later, and the line becomes Shared.
- R8: A snooped read-for-ownership (snoop_cmd_i = 1) that matches a valid line drives shared_o high one cycle later, and the line becomes Invalid. supply_o follows the same rule as for a snooped read.
- R9: A Shared holder drives supply_o only when no lower-index agent's bit is set in shared_vec_i in that cycle. Higher-index bits do not block it.
- R10: A snoop whose tag does not match, or that hits an Invalid line, leaves shared_o and supply_o low and does not change the stored line.
- R11: While bus_gnt_i is low, bus_req_o stays high with bus_cmd_o and bus_line_o unchanged.
- R12: The processor port does not complete an access while a snoop is presented or is being resolved in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| proc_req_i | input | 1 | Processor access request, held until done |
| proc_we_i | input | 1 | 1 = write, 0 = read |
| proc_line_i | input | LINE_AW | Line address of the access |
| proc_done_o | output | 1 | Access completes this cycle |
| bus_req_o | output | 1 | Bus transaction requested |
| bus_cmd_o | output | 1 | 0 = read, 1 = read-for-ownership |
| bus_line_o | output | LINE_AW | Line address of the bus request |
| bus_gnt_i | input | 1 | Own request is on the bus this cycle |
| snoop_valid_i | input | 1 | Another agent's transaction is on the bus |
| snoop_cmd_i | input | 1 | Snooped command, same encoding as bus_cmd_o |
| snoop_line_i | input | LINE_AW | Snooped line address |
| shared_o | output | 1 | This agent holds the snooped line (response cycle) |
| shared_vec_i | input | N_AGENTS | Holder bits of all agents, bit k = agent k |
| supply_o | output | 1 | This agent supplies the line data |

## Verification
The main function is exercised with four kinds of stimulus. A single-line walk drives one line through every state by local reads and writes and by snoops, which separates the silent upgrade from the bus-visible upgrade. Misses are replayed with the holder vector empty and with another agent's bit set, which shows whether the Exclusive or the Shared fill was taken. Snoops on a Shared line are repeated with a lower-index holder and with a higher-index holder present, which isolates the supplier priority. A same-index, different-tag address checks that a conflicting snoop leaves the line alone and that a conflicting miss evicts it.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic {
    CMD_RD  = 1'b0,
    CMD_RDX = 1'b1
  } bus_cmd_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_RESP = 2'd2
  } fsm_e;
endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
  import mesi_pkg::*;
#(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned TAG_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] p_idx_i,
  output logic [TAG_W-1:0] p_tag_o,
  output line_st_e         p_st_o,
  input  logic [IDX_W-1:0] s_idx_i,
  output logic [TAG_W-1:0] s_tag_o,
  output line_st_e         s_st_o,
  input  logic             fill_we_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  line_st_e         fill_st_i,
  input  logic             snp_we_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  line_st_e         snp_st_i,
  input  logic             upg_we_i,
  input  logic [IDX_W-1:0] upg_idx_i
);
  localparam int unsigned LINES = 1 << IDX_W;

  line_st_e         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  // own fill > snoop demotion > silent upgrade
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (fill_we_i && fill_idx_i == IDX_W'(i)) begin
          st_q[i]  <= fill_st_i;
          tag_q[i] <= fill_tag_i;
        end else if (snp_we_i && snp_idx_i == IDX_W'(i)) begin
          st_q[i] <= snp_st_i;
        end else if (upg_we_i && upg_idx_i == IDX_W'(i)) begin
          st_q[i] <= ST_M;
        end
      end
    end
  end

  assign p_tag_o = tag_q[p_idx_i];
  assign p_st_o  = st_q[p_idx_i];
  assign s_tag_o = tag_q[s_idx_i];
  assign s_st_o  = st_q[s_idx_i];

  // R4: silent upgrade only ever leaves Exclusive
  p_upg_from_e_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upg_we_i |-> st_q[upg_idx_i] == ST_E);

  // R5: an install never collides with a silent upgrade
  p_fill_upg_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_we_i && upg_we_i));
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned TAG_W    = 9,
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned AGENT_ID = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                snoop_valid_i,
  input  bus_cmd_e            snoop_cmd_i,
  input  logic [IDX_W-1:0]    snoop_idx_i,
  input  logic [TAG_W-1:0]    snoop_tag_i,
  input  logic [TAG_W-1:0]    look_tag_i,
  input  line_st_e            look_st_i,
  input  logic [N_AGENTS-1:0] shared_vec_i,
  output logic                shared_o,
  output logic                supply_o,
  output logic                busy_o,
  output logic                wr_we_o,
  output logic [IDX_W-1:0]    wr_idx_o,
  output line_st_e            wr_st_o
);
  localparam logic [N_AGENTS-1:0] LOWER_MASK =
    N_AGENTS'((64'd1 << AGENT_ID) - 64'd1);

  logic             pend_q;
  bus_cmd_e         cmd_q;
  logic [IDX_W-1:0] idx_q;
  line_st_e         hst_q;
  logic             hold;
  logic             prio_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cmd_q  <= CMD_RD;
      idx_q  <= '0;
      hst_q  <= ST_I;
    end else begin
      pend_q <= snoop_valid_i;
      if (snoop_valid_i) begin
        cmd_q <= snoop_cmd_i;
        idx_q <= snoop_idx_i;
        hst_q <= (look_tag_i == snoop_tag_i) ? look_st_i : ST_I;
      end
    end
  end

  assign hold     = pend_q && (hst_q != ST_I);
  assign prio_ok  = ~|(shared_vec_i & LOWER_MASK);
  assign shared_o = hold;
  assign supply_o = hold && ((hst_q == ST_M) || (hst_q == ST_E) || prio_ok);
  assign busy_o   = pend_q;
  assign wr_we_o  = hold;
  assign wr_idx_o = idx_q;
  assign wr_st_o  = (cmd_q == CMD_RDX) ? ST_I : ST_S;

  // R7: the holder bit only ever answers a snoop of the previous cycle
  p_shared_answers_snoop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shared_o |-> $past(snoop_valid_i));

  // R8: data is supplied only by an agent that reports a copy
  p_supply_needs_copy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_o |-> shared_o);
endmodule

// File: rtl/mesi_proc_fsm.sv
module mesi_proc_fsm
  import mesi_pkg::*;
#(
  parameter int unsigned LINE_AW  = 12,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned N_AGENTS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                proc_req_i,
  input  logic                proc_we_i,
  input  logic [LINE_AW-1:0]  proc_line_i,
  output logic                proc_done_o,
  input  logic [LINE_AW-IDX_W-1:0] look_tag_i,
  input  line_st_e            look_st_i,
  input  logic                blocked_i,
  output logic                bus_req_o,
  output bus_cmd_e            bus_cmd_o,
  output logic [LINE_AW-1:0]  bus_line_o,
  input  logic                bus_gnt_i,
  input  logic [N_AGENTS-1:0] shared_vec_i,
  output logic                fill_we_o,
  output logic [IDX_W-1:0]    fill_idx_o,
  output logic [LINE_AW-IDX_W-1:0] fill_tag_o,
  output line_st_e            fill_st_o,
  output logic                upg_we_o,
  output logic [IDX_W-1:0]    upg_idx_o
);
  localparam int unsigned TAG_W = LINE_AW - IDX_W;

  fsm_e               st_q, st_d;
  logic               we_q;
  bus_cmd_e           cmd_q;
  logic [LINE_AW-1:0] line_q;
  logic               match, hit, others;

  // own holder bit is low during own response: no snoop precedes it
  assign others = |shared_vec_i;
  assign match  = (look_tag_i == proc_line_i[LINE_AW-1:IDX_W]) && (look_st_i != ST_I);
  assign hit    = proc_we_i ? (match && (look_st_i == ST_M || look_st_i == ST_E)) : match;

  always_comb begin
    st_d        = st_q;
    proc_done_o = 1'b0;
    bus_req_o   = 1'b0;
    fill_we_o   = 1'b0;
    upg_we_o    = 1'b0;
    fill_st_o   = we_q ? ST_M : (others ? ST_S : ST_E);
    unique case (st_q)
      FS_IDLE: begin
        if (proc_req_i && !blocked_i) begin
          if (hit) begin
            proc_done_o = 1'b1;
            upg_we_o    = proc_we_i && (look_st_i == ST_E);
          end else begin
            st_d = FS_REQ;
          end
        end
      end
      FS_REQ: begin
        bus_req_o = 1'b1;
        if (bus_gnt_i) st_d = FS_RESP;
      end
      FS_RESP: begin
        proc_done_o = 1'b1;
        fill_we_o   = 1'b1;
        st_d        = FS_IDLE;
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FS_IDLE;
      we_q   <= 1'b0;
      cmd_q  <= CMD_RD;
      line_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == FS_IDLE && st_d == FS_REQ) begin
        we_q   <= proc_we_i;
        cmd_q  <= proc_we_i ? CMD_RDX : CMD_RD;
        line_q <= proc_line_i;
      end
    end
  end

  assign bus_cmd_o  = cmd_q;
  assign bus_line_o = line_q;
  assign fill_idx_o = line_q[IDX_W-1:0];
  assign fill_tag_o = line_q[LINE_AW-1:IDX_W];
  assign upg_idx_o  = proc_line_i[IDX_W-1:0];

  // R11: a pending request is held unchanged until granted
  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_line_o) && $stable(bus_cmd_o));

  // R2: the cycle after a grant completes the access and drops the request
  p_resp_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i |=> proc_done_o && !bus_req_o);

  // R12: nothing completes locally while a snoop is being resolved
  p_snoop_stall_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(blocked_i) && blocked_i && !$past(bus_gnt_i) |-> !proc_done_o);
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int unsigned LINE_AW  = 12,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned AGENT_ID = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                proc_req_i,
  input  logic                proc_we_i,
  input  logic [LINE_AW-1:0]  proc_line_i,
  output logic                proc_done_o,
  output logic                bus_req_o,
  output logic                bus_cmd_o,
  output logic [LINE_AW-1:0]  bus_line_o,
  input  logic                bus_gnt_i,
  input  logic                snoop_valid_i,
  input  logic                snoop_cmd_i,
  input  logic [LINE_AW-1:0]  snoop_line_i,
  output logic                shared_o,
  input  logic [N_AGENTS-1:0] shared_vec_i,
  output logic                supply_o
);
  localparam int unsigned TAG_W = LINE_AW - IDX_W;

  logic [TAG_W-1:0] p_tag, s_tag, fill_tag;
  line_st_e         p_st, s_st, fill_st, snp_st;
  logic             fill_we, snp_we, upg_we, snp_busy;
  logic [IDX_W-1:0] fill_idx, snp_idx, upg_idx;
  bus_cmd_e         cmd_e, snp_cmd_e;

  assign snp_cmd_e = bus_cmd_e'(snoop_cmd_i);
  assign bus_cmd_o = cmd_e;

  mesi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .p_idx_i    (proc_line_i[IDX_W-1:0]),
    .p_tag_o    (p_tag),
    .p_st_o     (p_st),
    .s_idx_i    (snoop_line_i[IDX_W-1:0]),
    .s_tag_o    (s_tag),
    .s_st_o     (s_st),
    .fill_we_i  (fill_we),
    .fill_idx_i (fill_idx),
    .fill_tag_i (fill_tag),
    .fill_st_i  (fill_st),
    .snp_we_i   (snp_we),
    .snp_idx_i  (snp_idx),
    .snp_st_i   (snp_st),
    .upg_we_i   (upg_we),
    .upg_idx_i  (upg_idx)
  );

  mesi_snoop_unit #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .N_AGENTS(N_AGENTS), .AGENT_ID(AGENT_ID)
  ) u_snoop (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .snoop_valid_i (snoop_valid_i),
    .snoop_cmd_i   (snp_cmd_e),
    .snoop_idx_i   (snoop_line_i[IDX_W-1:0]),
    .snoop_tag_i   (snoop_line_i[LINE_AW-1:IDX_W]),
    .look_tag_i    (s_tag),
    .look_st_i     (s_st),
    .shared_vec_i  (shared_vec_i),
    .shared_o      (shared_o),
    .supply_o      (supply_o),
    .busy_o        (snp_busy),
    .wr_we_o       (snp_we),
    .wr_idx_o      (snp_idx),
    .wr_st_o       (snp_st)
  );

  mesi_proc_fsm #(
    .LINE_AW(LINE_AW), .IDX_W(IDX_W), .N_AGENTS(N_AGENTS)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .proc_req_i   (proc_req_i),
    .proc_we_i    (proc_we_i),
    .proc_line_i  (proc_line_i),
    .proc_done_o  (proc_done_o),
    .look_tag_i   (p_tag),
    .look_st_i    (p_st),
    .blocked_i    (snoop_valid_i || snp_busy),
    .bus_req_o    (bus_req_o),
    .bus_cmd_o    (cmd_e),
    .bus_line_o   (bus_line_o),
    .bus_gnt_i    (bus_gnt_i),
    .shared_vec_i (shared_vec_i),
    .fill_we_o    (fill_we),
    .fill_idx_o   (fill_idx),
    .fill_tag_o   (fill_tag),
    .fill_st_o    (fill_st),
    .upg_we_o     (upg_we),
    .upg_idx_o    (upg_idx)
  );

  // R10: own bus request and snoop demotion never hit the same cycle
  p_fill_snoop_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_we && snp_we));
endmodule

// File: tb/mesi_snoop_ctrl_bench.sv
module mesi_snoop_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        op;    // 0 access, 1 snoop
    logic        wr;    // write / read-for-ownership
    logic [11:0] line;
    logic [3:0]  svec;
    logic [1:0]  ebus;  // 0 none, 1 read, 2 read-for-ownership
    logic        esh;
    logic        esup;
    logic [3:0]  rq;
  } vec_t;

  // A=0x004 idx4 tag0, B=0x00C idx4 tag1, C=0x002 idx2, agent id 1
  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,12'h004,4'h0,2'd1,1'b0,1'b0,4'd2},  // R2 miss -> E
    '{1'b0,1'b0,12'h004,4'h0,2'd0,1'b0,1'b0,4'd6},  // R6 hit E
    '{1'b0,1'b1,12'h004,4'h0,2'd0,1'b0,1'b0,4'd4},  // R4 silent E->M
    '{1'b0,1'b0,12'h004,4'h0,2'd0,1'b0,1'b0,4'd6},  // R6 hit M
    '{1'b1,1'b0,12'h004,4'h0,2'd0,1'b1,1'b1,4'd7},  // R7 M -> S
    '{1'b0,1'b1,12'h004,4'h0,2'd2,1'b0,1'b0,4'd5},  // R5 S -> M via bus
    '{1'b1,1'b1,12'h004,4'h0,2'd0,1'b1,1'b1,4'd8},  // R8 M -> I
    '{1'b0,1'b0,12'h004,4'h4,2'd1,1'b0,1'b0,4'd8},  // R8 now a miss, fill S
    '{1'b0,1'b1,12'h004,4'h0,2'd2,1'b0,1'b0,4'd3},  // R3 S needs bus to write
    '{1'b1,1'b0,12'h00C,4'h0,2'd0,1'b0,1'b0,4'd10}, // R10 tag mismatch
    '{1'b0,1'b0,12'h004,4'h0,2'd0,1'b0,1'b0,4'd10}, // R10 still M
    '{1'b1,1'b0,12'h004,4'h1,2'd0,1'b1,1'b1,4'd7},  // R7 M supplies anyway
    '{1'b1,1'b0,12'h004,4'h1,2'd0,1'b1,1'b0,4'd9},  // R9 lower holder wins
    '{1'b1,1'b0,12'h004,4'h4,2'd0,1'b1,1'b1,4'd9},  // R9 higher holder ignored
    '{1'b1,1'b1,12'h004,4'h1,2'd0,1'b1,1'b0,4'd8},  // R8 S -> I, no supply
    '{1'b0,1'b0,12'h004,4'h0,2'd1,1'b0,1'b0,4'd8},  // R8 miss -> E
    '{1'b0,1'b1,12'h002,4'h0,2'd2,1'b0,1'b0,4'd5},  // R5 write miss
    '{1'b0,1'b0,12'h002,4'h0,2'd0,1'b0,1'b0,4'd6},  // R6 hit M
    '{1'b0,1'b0,12'h00C,4'h0,2'd1,1'b0,1'b0,4'd2},  // R2 evicts A
    '{1'b0,1'b0,12'h004,4'h0,2'd1,1'b0,1'b0,4'd2}   // R2 A misses again
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        proc_req_i = 1'b0, proc_we_i = 1'b0;
  logic [11:0] proc_line_i = '0;
  logic        proc_done_o, bus_req_o, bus_cmd_o;
  logic [11:0] bus_line_o;
  logic        bus_gnt_i = 1'b0;
  logic        snoop_valid_i = 1'b0, snoop_cmd_i = 1'b0;
  logic [11:0] snoop_line_i = '0;
  logic        shared_o, supply_o;
  logic [3:0]  shared_vec_i = '0;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mesi_snoop_ctrl u_mesi_snoop_ctrl (
    .clk_i, .rst_ni, .proc_req_i, .proc_we_i, .proc_line_i, .proc_done_o,
    .bus_req_o, .bus_cmd_o, .bus_line_o, .bus_gnt_i,
    .snoop_valid_i, .snoop_cmd_i, .snoop_line_i,
    .shared_o, .shared_vec_i, .supply_o
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [11:0] line,
                        input logic [3:0] svec, input logic [1:0] ebus, input string rq);
    @(negedge clk_i);
    proc_req_i = 1'b1; proc_we_i = we; proc_line_i = line;
    #1;
    if (ebus == 2'd0) begin
      chk(rq, "hit done", proc_done_o, 1);
      chk(rq, "hit bus_req", bus_req_o, 0);
      @(negedge clk_i);
    end else begin
      chk(rq, "miss done", proc_done_o, 0);
      @(negedge clk_i); #1;
      chk(rq, "bus_req", bus_req_o, 1);
      chk(rq, "bus_cmd", bus_cmd_o, (ebus == 2'd2));
      chk(rq, "bus_line", bus_line_o, line);
      bus_gnt_i = 1'b1;
      @(negedge clk_i);
      bus_gnt_i = 1'b0; shared_vec_i = svec;
      #1;
      chk(rq, "resp done", proc_done_o, 1);
      chk(rq, "resp bus_req", bus_req_o, 0);
      @(negedge clk_i);
    end
    proc_req_i = 1'b0; shared_vec_i = '0;
  endtask

  task automatic snoop(input logic cmd, input logic [11:0] line, input logic [3:0] svec,
                       input logic esh, input logic esup, input string rq);
    @(negedge clk_i);
    snoop_valid_i = 1'b1; snoop_cmd_i = cmd; snoop_line_i = line;
    @(negedge clk_i);
    snoop_valid_i = 1'b0; shared_vec_i = svec;
    #1;
    chk(rq, "shared_o", shared_o, esh);
    chk(rq, "supply_o", supply_o, esup);
    @(negedge clk_i);
    shared_vec_i = '0;
  endtask

  task automatic idle_check(input string rq);
    chk(rq, "idle done", proc_done_o, 0);
    chk(rq, "idle bus_req", bus_req_o, 0);
    chk(rq, "idle shared", shared_o, 0);
    chk(rq, "idle supply", supply_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #1 idle_check("R1");

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", TBL[i].rq);
      if (TBL[i].op == 1'b0)
        access(TBL[i].wr, TBL[i].line, TBL[i].svec, TBL[i].ebus, rq);
      else
        snoop(TBL[i].wr, TBL[i].line, TBL[i].svec, TBL[i].esh, TBL[i].esup, rq);
    end

    // R11: grant withheld, request held steady (D=0x012 evicts C)
    @(negedge clk_i);
    proc_req_i = 1'b1; proc_we_i = 1'b0; proc_line_i = 12'h012;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i); #1;
      chk("R11", "held req", bus_req_o, 1);
      chk("R11", "held line", bus_line_o, 12'h012);
      chk("R11", "held cmd", bus_cmd_o, 0);
    end
    bus_gnt_i = 1'b1;
    @(negedge clk_i);
    bus_gnt_i = 1'b0;
    #1 chk("R11", "done after grant", proc_done_o, 1);
    @(negedge clk_i);
    proc_req_i = 1'b0;

    // R12: read hit on A (Exclusive) stalls behind a snoop of Invalid C
    @(negedge clk_i);
    snoop_valid_i = 1'b1; snoop_cmd_i = 1'b0; snoop_line_i = 12'h002;
    proc_req_i = 1'b1; proc_we_i = 1'b0; proc_line_i = 12'h004;
    #1 chk("R12", "stall in snoop cycle", proc_done_o, 0);
    @(negedge clk_i);
    snoop_valid_i = 1'b0;
    #1 chk("R12", "stall in resolve cycle", proc_done_o, 0);
    chk("R10", "invalid snoop shared", shared_o, 0);
    chk("R10", "invalid snoop supply", supply_o, 0);
    @(negedge clk_i); #1;
    chk("R12", "done after snoop", proc_done_o, 1);
    chk("R6", "stalled hit no bus", bus_req_o, 0);
    @(negedge clk_i);
    proc_req_i = 1'b0;

    // R1: reset clears every line
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #1 idle_check("R1");
    access(1'b0, 12'h004, 4'h0, 2'd1, "R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule